// File: doc/BRIEF.md
# Handshake Pipeline Chain with Periodic Skid Stages

This block carries a data word through a configurable number of registered stages between an upstream valid/ready port and a downstream valid/ready port. A beat moves one stage forward on each clock edge. When the sink stops taking beats, each stage keeps the beat it holds, and the stall travels back toward the source one stage at a time. No beat is dropped, duplicated or reordered. When nothing stalls, one beat passes through per clock.

There are two kinds of stage. A single-slot stage holds one beat. Its upstream ready is formed combinationally from its own occupancy and the ready of the next stage. A skid stage holds up to two beats, and its upstream ready comes straight from a flop, so no combinational ready path runs through it. The parameter `SKID_EVERY` places a skid stage at the end of every group of that many stages. This bounds the longest combinational ready chain. A per-stage fill output shows how many beats each stage holds, which is useful for watching a stall build up along the chain.

Top module: `hs_pipe_chain`

## Requirements
- R1: An active-low synchronous reset empties every stage. After reset, `validDown` is 0, `stageFill` is all zeros and `readyUp` is 1. Payload registers are not cleared.
- R2: Beats leave in the order they were accepted. Each beat leaves exactly once, with its data unchanged.
- R3: With `readyDown` held high and `validUp` held high, a beat accepted in cycle t is presented at the output in cycle t+N_STAGES, and one beat leaves on every cycle after that.
- R4: Once `validDown` is high and `readyDown` is low, `validDown` stays high in the next cycle and `dataDown` stays the same.
- R5: With the sink stalled, the chain accepts exactly its capacity and then holds `readyUp` low. The capacity is one beat per single-slot stage plus two beats per skid stage.
- R6: Stage i (counting from 0 at the input) is a skid stage when `SKID_EVERY` > 0 and (i+1) is a multiple of `SKID_EVERY`. All other stages are single-slot. A skid stage raises its upstream ready from a register that is low only while its second slot is occupied.
- R7: `stageFill[2*i+1:2*i]` gives the number of beats held in stage i, from 0 to 2. When the chain is full and stalled, single-slot stages show 1 and skid stages show 2.
- R8: When the sink resumes with no new input, a full chain delivers all of its capacity on consecutive cycles.
- R9: Cycles with `validUp` low add no beats. Under random input gaps and random sink stalls, the number of beats delivered equals the number accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| validUp | input | 1 | Upstream beat present |
| readyUp | output | 1 | Chain can accept a beat this cycle |
| dataUp | input | DATA_W | Upstream payload |
| validDown | output | 1 | Downstream beat present |
| readyDown | input | 1 | Sink takes the beat this cycle |
| dataDown | output | DATA_W | Downstream payload |
| stageFill | output | 2*N_STAGES | Beats held per stage, two bits each |

## Verification
The in-line assertions check local rules on every cycle:
- a stalled stage output keeps its valid flag and its data;
- a skid stage never holds a second beat without a first;
- a skid stage keeps its second beat while its output is blocked;
- a skid stage empties its second slot only on a cycle when its first beat leaves.

Properties that involve the whole chain can only be shown by the bench scenarios:
- latency equal to the stage count;
- back-to-back throughput;
- exact capacity before the upstream ready drops;
- the fill pattern at saturation;
- a full drain on consecutive cycles;
- order and count kept under a random stall storm.

// File: rtl/hs_pipe_pkg.sv
`timescale 1ns/1ps
package hs_pipe_pkg;

  // Load strobes sent from a stage's control half to its data half.
  typedef struct packed {
    logic loadMainUp;    // primary slot takes the upstream word
    logic loadMainSide;  // primary slot takes the word parked in the side slot
    logic loadSide;      // side slot parks the upstream word
  } stage_strobe_t;

  // Placement rule for skid stages: last stage of every group of `every`.
  function automatic bit stageIsSkid(input int idx, input int every);
    if (every <= 0) return 1'b0;
    return ((idx + 1) % every) == 0;
  endfunction

endpackage

// File: rtl/hs_stage_ctrl.sv
`timescale 1ns/1ps
module hs_stage_ctrl
  import hs_pipe_pkg::*;
#(
  parameter bit IS_SKID = 1'b0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          validIn,
  output logic          readyIn,
  output logic          validOut,
  input  logic          readyOut,
  output stage_strobe_t strb,
  output logic [1:0]    fill
);

  logic mainValid;
  logic mainFree;

  assign validOut = mainValid;
  assign mainFree = !mainValid || readyOut;

  generate
    if (IS_SKID) begin : g_skid
      logic sideValid;

      // Upstream ready is a flop output: low only while the side slot is used.
      assign readyIn = !sideValid;

      always_comb begin
        strb.loadMainSide = mainFree && sideValid;
        strb.loadMainUp   = mainFree && !sideValid && validIn;
        strb.loadSide     = !mainFree && !sideValid && validIn;
      end

      always_ff @(posedge clk) begin
        if (!rstN) begin
          mainValid <= 1'b0;
          sideValid <= 1'b0;
        end else begin
          if (mainFree) mainValid <= sideValid || validIn;
          if (strb.loadMainSide)  sideValid <= 1'b0;
          else if (strb.loadSide) sideValid <= 1'b1;
        end
      end

      assign fill = {1'b0, mainValid} + {1'b0, sideValid};

      // R7: a parked second beat always sits behind a primary beat
      p_side_behind_main_r7: assert property (@(posedge clk) disable iff (!rstN)
        sideValid |-> mainValid);

      // R2: the parked beat is kept while the output is blocked
      p_side_kept_r2: assert property (@(posedge clk) disable iff (!rstN)
        (sideValid && !readyOut) |=> sideValid);

      // R6: the side slot empties only on a cycle when the primary beat leaves
      p_side_drain_r6: assert property (@(posedge clk) disable iff (!rstN)
        $fell(sideValid) |-> $past(readyOut));

    end else begin : g_slot
      // Single-slot stage: ready passes combinationally from downstream.
      assign readyIn = mainFree;

      always_comb begin
        strb.loadMainUp   = mainFree && validIn;
        strb.loadMainSide = 1'b0;
        strb.loadSide     = 1'b0;
      end

      always_ff @(posedge clk) begin
        if (!rstN)         mainValid <= 1'b0;
        else if (mainFree) mainValid <= validIn;
      end

      assign fill = {1'b0, mainValid};
    end
  endgenerate

  // R4: a stalled output keeps its valid flag
  p_hold_valid_r4: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && !readyOut) |=> validOut);

endmodule

// File: rtl/hs_stage_data.sv
`timescale 1ns/1ps
module hs_stage_data
  import hs_pipe_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter bit IS_SKID = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  stage_strobe_t     strb,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              validOut,
  input  logic              readyOut,
  output logic [DATA_W-1:0] dataOut
);

  logic [DATA_W-1:0] mainData;
  assign dataOut = mainData;

  generate
    if (IS_SKID) begin : g_skid
      logic [DATA_W-1:0] sideData;

      always_ff @(posedge clk) begin
        if (strb.loadMainSide)    mainData <= sideData;
        else if (strb.loadMainUp) mainData <= dataIn;
        if (strb.loadSide)        sideData <= dataIn;
      end

      // R2: the primary slot is never loaded from both sources at once
      p_one_source_r2: assert property (@(posedge clk) disable iff (!rstN)
        !(strb.loadMainSide && strb.loadMainUp));
    end else begin : g_slot
      always_ff @(posedge clk) begin
        if (strb.loadMainUp) mainData <= dataIn;
      end

      // R6: a single-slot stage never uses side-slot strobes
      always_comb begin
        if (rstN) begin
          a_no_side_r6: assert (!strb.loadSide && !strb.loadMainSide);
        end
      end
    end
  endgenerate

  // R4: a stalled output word is not overwritten
  p_hold_data_r4: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && !readyOut) |=> $stable(dataOut));

endmodule

// File: rtl/hs_pipe_stage.sv
`timescale 1ns/1ps
module hs_pipe_stage
  import hs_pipe_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter bit IS_SKID = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              validIn,
  output logic              readyIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              validOut,
  input  logic              readyOut,
  output logic [DATA_W-1:0] dataOut,
  output logic [1:0]        fill
);

  stage_strobe_t strb;

  hs_stage_ctrl #(.IS_SKID(IS_SKID)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .validIn  (validIn),
    .readyIn  (readyIn),
    .validOut (validOut),
    .readyOut (readyOut),
    .strb     (strb),
    .fill     (fill)
  );

  hs_stage_data #(.DATA_W(DATA_W), .IS_SKID(IS_SKID)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .dataIn   (dataIn),
    .validOut (validOut),
    .readyOut (readyOut),
    .dataOut  (dataOut)
  );

endmodule

// File: rtl/hs_pipe_chain.sv
`timescale 1ns/1ps
module hs_pipe_chain
  import hs_pipe_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int N_STAGES   = 4,
  parameter int SKID_EVERY = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  validUp,
  output logic                  readyUp,
  input  logic [DATA_W-1:0]     dataUp,
  output logic                  validDown,
  input  logic                  readyDown,
  output logic [DATA_W-1:0]     dataDown,
  output logic [2*N_STAGES-1:0] stageFill
);

  localparam int FILL_W = 2 * N_STAGES;

  logic [N_STAGES:0]             linkValid;
  logic [N_STAGES:0]             linkReady;
  logic [N_STAGES:0][DATA_W-1:0] linkData;

  assign linkValid[0]        = validUp;
  assign linkData[0]         = dataUp;
  assign readyUp             = linkReady[0];
  assign validDown           = linkValid[N_STAGES];
  assign dataDown            = linkData[N_STAGES];
  assign linkReady[N_STAGES] = readyDown;

  for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
    hs_pipe_stage #(
      .DATA_W  (DATA_W),
      .IS_SKID (stageIsSkid(i, SKID_EVERY))
    ) u_stage (
      .clk      (clk),
      .rstN     (rstN),
      .validIn  (linkValid[i]),
      .readyIn  (linkReady[i]),
      .dataIn   (linkData[i]),
      .validOut (linkValid[i+1]),
      .readyOut (linkReady[i+1]),
      .dataOut  (linkData[i+1]),
      .fill     (stageFill[2*i +: 2])
    );
  end

  // R1: in the cycle after a reset edge the output side is empty
  p_reset_empty_r1: assert property (@(posedge clk)
    !rstN |=> (validDown == 1'b0) && (stageFill == {FILL_W{1'b0}}));

endmodule

// File: tb/sim_hs_pipe_chain.sv
`timescale 1ns/1ps
module sim_hs_pipe_chain;

  localparam int DATA_W     = 16;
  localparam int N_STAGES   = 4;
  localparam int SKID_EVERY = 2;
  localparam int FILL_W     = 2 * N_STAGES;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              validUp = 1'b0;
  logic              readyUp;
  logic [DATA_W-1:0] dataUp = '0;
  logic              validDown;
  logic              readyDown = 1'b0;
  logic [DATA_W-1:0] dataDown;
  logic [FILL_W-1:0] stageFill;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [DATA_W-1:0] sb[$];
  int                inCyc[$];
  int                cyc = 0;
  int                inCount = 0;
  int                outCount = 0;
  logic [DATA_W-1:0] nextData = 16'h0100;
  bit                chkLatency = 1'b0;
  bit                prevStall = 1'b0;
  logic [DATA_W-1:0] prevData = '0;
  bit                lastIn, lastOut;

  always #10 clk = ~clk;  // 50 MHz

  hs_pipe_chain #(
    .DATA_W(DATA_W), .N_STAGES(N_STAGES), .SKID_EVERY(SKID_EVERY)
  ) u0 (
    .clk(clk), .rstN(rstN),
    .validUp(validUp), .readyUp(readyUp), .dataUp(dataUp),
    .validDown(validDown), .readyDown(readyDown), .dataDown(dataDown),
    .stageFill(stageFill)
  );

  function automatic bit benchSkid(input int i);
    return (SKID_EVERY > 0) && (((i + 1) % SKID_EVERY) == 0);
  endfunction

  function automatic int capacity();
    int c = 0;
    for (int i = 0; i < N_STAGES; i++) c += benchSkid(i) ? 2 : 1;
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One cycle: drive at negedge, evaluate the handshakes before the next posedge.
  task automatic step(input bit vIn, input bit rDown);
    @(negedge clk);
    validUp = vIn; readyDown = rDown; dataUp = nextData;
    #1;
    lastIn  = vIn && readyUp;
    lastOut = validDown && rDown;
    if (prevStall) begin
      check(validDown == 1'b1, "R4", "valid dropped while stalled", validDown, 1);
      check(dataDown == prevData, "R4", "data changed while stalled", dataDown, prevData);
    end
    prevStall = validDown && !rDown;
    prevData  = dataDown;
    if (lastIn) begin
      sb.push_back(nextData); inCyc.push_back(cyc);
      nextData++; inCount++;
    end
    if (lastOut) begin
      outCount++;
      if (sb.size() == 0) begin
        check(1'b0, "R9", "output beat with nothing accepted", dataDown, 0);
      end else begin
        logic [DATA_W-1:0] e;
        int t;
        e = sb.pop_front(); t = inCyc.pop_front();
        check(dataDown == e, "R2", "beat data/order", dataDown, e);
        if (chkLatency) check(cyc - t == N_STAGES, "R3", "latency", cyc - t, N_STAGES);
      end
    end
    cyc++;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; validUp = 1'b0; readyDown = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    sb.delete(); inCyc.delete(); prevStall = 1'b0;
    inCount = 0; outCount = 0;
  endtask

  task automatic testReset();
    doReset();
    #1;
    check(validDown == 1'b0, "R1", "validDown after reset", validDown, 0);
    check(stageFill == '0, "R1", "stageFill after reset", stageFill, 0);
    check(readyUp == 1'b1, "R1", "readyUp after reset", readyUp, 1);
  endtask

  task automatic testStream();
    int outs = 0;
    chkLatency = 1'b1;
    for (int k = 0; k < 40; k++) begin
      step(1'b1, 1'b1);
      if (lastOut) outs++;
    end
    chkLatency = 1'b0;
    check(outs == 40 - N_STAGES, "R3", "back-to-back output count", outs, 40 - N_STAGES);
    for (int k = 0; k < N_STAGES + 2; k++) step(1'b0, 1'b1);
    check(sb.size() == 0, "R2", "stream leftover beats", sb.size(), 0);
  endtask

  task automatic testStallFill();
    int acc = 0;
    for (int k = 0; k < 3 * capacity() + 6; k++) begin
      step(1'b1, 1'b0);
      if (lastIn) acc++;
    end
    check(acc == capacity(), "R5", "beats accepted while stalled", acc, capacity());
    #1;
    check(readyUp == 1'b0, "R5", "readyUp when full", readyUp, 0);
    for (int i = 0; i < N_STAGES; i++) begin
      int exp = benchSkid(i) ? 2 : 1;
      check(stageFill[2*i +: 2] == exp, (benchSkid(i) ? "R6" : "R7"),
            $sformatf("fill of stage %0d", i), stageFill[2*i +: 2], exp);
    end
  endtask

  task automatic testDrain();
    int run = 0;
    bit broken = 1'b0;
    for (int k = 0; k < capacity() + 4; k++) begin
      step(1'b0, 1'b1);
      if (lastOut && !broken) run++;
      else if (run > 0) broken = 1'b1;
    end
    check(run == capacity(), "R8", "consecutive drain beats", run, capacity());
    check(stageFill == '0, "R8", "fill after drain", stageFill, 0);
  endtask

  task automatic testMidReset();
    testStallFill();
    doReset();
    #1;
    check(stageFill == '0, "R1", "fill after mid-run reset", stageFill, 0);
    check(validDown == 1'b0, "R1", "validDown after mid-run reset", validDown, 0);
  endtask

  task automatic testStorm();
    for (int k = 0; k < 3000; k++) begin
      step(($urandom % 4) != 0, ($urandom % 3) != 0);
    end
    for (int k = 0; k < capacity() + 4; k++) step(1'b0, 1'b1);
    check(outCount == inCount, "R9", "delivered vs accepted", outCount, inCount);
    check(sb.size() == 0, "R2", "storm leftover beats", sb.size(), 0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    testReset();
    testStream();
    testStallFill();
    testDrain();
    testMidReset();
    testStorm();
    finish();
  end

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish();
  end

endmodule